// File: doc/BRIEF.md
# Three-State Processor Power-Mode Sequencer

This block steers a processor core between three operating levels: full activity (run), a light rest where the core clock is stopped but every domain stays supplied (idle), and a deep rest where the supplies of the switchable domains are removed (sleep). Software raises a request to rest lightly or deeply. A wake event brings the core back to full activity. The block drives the core clock enable and, for each switchable domain, an isolation enable and a supply enable. It also reports a state code, a coarse power-level code and a busy flag.

Every move between levels takes a fixed number of cycles. Each of these counts is a parameter, and the four counts need not be equal. Entering the deep rest is a staged sequence of three steps: the clock is stopped, then the domain outputs are isolated, then the domain supplies are removed. Waking undoes these steps in the opposite order. While any move is under way the block is busy and takes no notice of requests or wake events.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Right after reset the block is at rest in run: `stateCode` 0, `coreClkEn` 1, every `isoEn` bit 0, every `domPwrEn` bit 1, and `busy` 0.
- R2: In run, a light-rest request without a deep-rest request gives `stateCode` 3 with `coreClkEn` 0 for exactly `IDLE_ENTER_CYC` cycles. After that the block reports `stateCode` 1 (idle), with the clock still off and the domains still supplied and not isolated.
- R3: In idle, a wake event gives `stateCode` 4 with `coreClkEn` 1 for exactly `IDLE_EXIT_CYC` cycles, then `stateCode` 0.
- R4: A deep-rest request accepted in run or in idle gives `stateCode` 5 for exactly `SLEEP_ENTER_CYC` cycles, split into three steps. In the first step, of `SLEEP_ENTER_CYC/3` cycles, only the clock is off. In the second step, of the same length, isolation is also on. In the third step, which takes the remaining cycles, the domain supplies are also off. The block then reports `stateCode` 2 (sleep) and keeps the rails as in the third step.
- R5: In sleep, a wake event gives `stateCode` 6 for exactly `WAKE_CYC` cycles. In the first `WAKE_CYC/3` cycles the supplies are on, with isolation on and the clock off. In the next `WAKE_CYC/3` cycles isolation is off as well. In the remaining cycles the clock is on as well. The block then reports `stateCode` 0.
- R6: `busy` is 1 exactly while `stateCode` is 3, 4, 5 or 6. Requests and wake events seen while busy are dropped and change nothing.
- R7: When several inputs are high at once, the outcome follows a fixed order. In run, a deep-rest request wins over a light-rest request, and a wake event is ignored. In idle, a wake event wins over a deep-rest request, and a light-rest request is ignored. In sleep, both kinds of request are ignored.
- R8: `powerCode` is 2 in run, 1 in idle, 0 in sleep and 3 in any transitional state.
- R9: A domain whose supply is off always has its isolation on. While any isolation is on, `coreClkEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIdle | input | 1 | Software request for the light rest |
| reqSleep | input | 1 | Software request for the deep rest |
| wakeEvt | input | 1 | Wake event |
| coreClkEn | output | 1 | Core clock enable |
| isoEn | output | NUM_DOMAINS | Output isolation enable, one bit per domain |
| domPwrEn | output | NUM_DOMAINS | Supply enable, one bit per domain |
| stateCode | output | 3 | 0 run, 1 idle, 2 sleep, 3 entering idle, 4 leaving idle, 5 entering sleep, 6 waking |
| powerCode | output | 2 | Power level: 2 high, 1 low, 0 minimal, 3 transitional |
| busy | output | 1 | A transition is in progress |

## Verification
The bench builds the block with three domains and short latencies: 4 cycles to enter idle, 3 to leave it, 10 to enter sleep and 14 to wake. With these values a full deep-rest round trip takes a few dozen cycles, so thousands of random request patterns cover every state many times over. The deep-rest and wake counts are not multiples of three, so the third step must absorb the remainder, and each step boundary is checked cycle by cycle. The unequal idle entry and exit counts show any mix-up between the two latencies.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [3:0] {
    PH_RUN, PH_TO_IDLE, PH_IDLE, PH_TO_RUN,
    PH_GATE, PH_ISOLATE, PH_POWER_OFF, PH_SLEEP,
    PH_POWER_ON, PH_RELEASE, PH_UNGATE
  } phase_e;

  typedef enum logic [2:0] {
    LEN_IDLE_IN, LEN_IDLE_OUT,
    LEN_STEP_A, LEN_STEP_B, LEN_STEP_C,
    LEN_WAKE_A, LEN_WAKE_B, LEN_WAKE_C
  } len_sel_e;

  typedef struct packed {
    logic     load;
    len_sel_e lenSel;
    logic     clkOn;
    logic     clkOff;
    logic     isoOn;
    logic     isoOff;
    logic     pwrOn;
    logic     pwrOff;
  } strobe_t;

  localparam logic [2:0] CODE_RUN       = 3'd0;
  localparam logic [2:0] CODE_IDLE      = 3'd1;
  localparam logic [2:0] CODE_SLEEP     = 3'd2;
  localparam logic [2:0] CODE_TO_IDLE   = 3'd3;
  localparam logic [2:0] CODE_TO_RUN    = 3'd4;
  localparam logic [2:0] CODE_TO_SLEEP  = 3'd5;
  localparam logic [2:0] CODE_WAKING    = 3'd6;

  localparam logic [1:0] LVL_MIN   = 2'd0;
  localparam logic [1:0] LVL_LOW   = 2'd1;
  localparam logic [1:0] LVL_HIGH  = 2'd2;
  localparam logic [1:0] LVL_TRANS = 2'd3;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int IDLE_ENTER_CYC  = 10,
  parameter int IDLE_EXIT_CYC   = 10,
  parameter int SLEEP_ENTER_CYC = 90,
  parameter int WAKE_CYC        = 160,
  parameter int NUM_DOMAINS     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  output logic                   cntZero,
  output logic                   coreClkEn,
  output logic [NUM_DOMAINS-1:0] isoEn,
  output logic [NUM_DOMAINS-1:0] domPwrEn
);

  localparam int STEP_AB   = SLEEP_ENTER_CYC / 3;
  localparam int STEP_C    = SLEEP_ENTER_CYC - 2 * STEP_AB;
  localparam int WSTEP_AB  = WAKE_CYC / 3;
  localparam int WSTEP_C   = WAKE_CYC - 2 * WSTEP_AB;
  localparam int MAX_A     = (IDLE_ENTER_CYC > IDLE_EXIT_CYC) ? IDLE_ENTER_CYC : IDLE_EXIT_CYC;
  localparam int MAX_B     = (STEP_C > WSTEP_C) ? STEP_C : WSTEP_C;
  localparam int MAX_LAT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strb.lenSel)
      LEN_IDLE_IN:  loadVal = CNT_W'(IDLE_ENTER_CYC - 1);
      LEN_IDLE_OUT: loadVal = CNT_W'(IDLE_EXIT_CYC - 1);
      LEN_STEP_A,
      LEN_STEP_B:   loadVal = CNT_W'(STEP_AB - 1);
      LEN_STEP_C:   loadVal = CNT_W'(STEP_C - 1);
      LEN_WAKE_A,
      LEN_WAKE_B:   loadVal = CNT_W'(WSTEP_AB - 1);
      LEN_WAKE_C:   loadVal = CNT_W'(WSTEP_C - 1);
      default:      loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.load)     cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             coreClkEn <= 1'b1;
    else if (strb.clkOn)   coreClkEn <= 1'b1;
    else if (strb.clkOff)  coreClkEn <= 1'b0;
  end

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_domain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             isoEn[g] <= 1'b0;
      else if (strb.isoOn)   isoEn[g] <= 1'b1;
      else if (strb.isoOff)  isoEn[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             domPwrEn[g] <= 1'b1;
      else if (strb.pwrOn)   domPwrEn[g] <= 1'b1;
      else if (strb.pwrOff)  domPwrEn[g] <= 1'b0;
    end

    // R9: an unsupplied domain must be isolated
    p_iso_covers_off_r9: assert property (@(posedge clk) disable iff (!rstN)
      !domPwrEn[g] |-> isoEn[g]);
  end

  // R9: isolation only while the clock is stopped
  p_clk_off_when_isolated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|isoEn) |-> !coreClkEn);

  // R6: the latency counter runs down one per cycle unless reloaded
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqIdle,
  input  logic       reqSleep,
  input  logic       wakeEvt,
  input  logic       cntZero,
  output strobe_t    strb,
  output logic [2:0] stateCode,
  output logic [1:0] powerCode,
  output logic       busy
);

  phase_e phase, nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RUN;
    else       phase <= nextPhase;
  end

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_RUN: begin
        if (reqSleep)     nextPhase = PH_GATE;
        else if (reqIdle) nextPhase = PH_TO_IDLE;
      end
      PH_IDLE: begin
        if (wakeEvt)       nextPhase = PH_TO_RUN;
        else if (reqSleep) nextPhase = PH_GATE;
      end
      PH_SLEEP:     if (wakeEvt) nextPhase = PH_POWER_ON;
      PH_TO_IDLE:   if (cntZero) nextPhase = PH_IDLE;
      PH_TO_RUN:    if (cntZero) nextPhase = PH_RUN;
      PH_GATE:      if (cntZero) nextPhase = PH_ISOLATE;
      PH_ISOLATE:   if (cntZero) nextPhase = PH_POWER_OFF;
      PH_POWER_OFF: if (cntZero) nextPhase = PH_SLEEP;
      PH_POWER_ON:  if (cntZero) nextPhase = PH_RELEASE;
      PH_RELEASE:   if (cntZero) nextPhase = PH_UNGATE;
      PH_UNGATE:    if (cntZero) nextPhase = PH_RUN;
      default:      nextPhase = PH_RUN;
    endcase
  end

  // strobes issued on the edge that enters a phase
  always_comb begin
    strb = '0;
    if (nextPhase != phase) begin
      unique case (nextPhase)
        PH_TO_IDLE:   begin strb.load = 1'b1; strb.lenSel = LEN_IDLE_IN;  strb.clkOff = 1'b1; end
        PH_TO_RUN:    begin strb.load = 1'b1; strb.lenSel = LEN_IDLE_OUT; strb.clkOn  = 1'b1; end
        PH_GATE:      begin strb.load = 1'b1; strb.lenSel = LEN_STEP_A;   strb.clkOff = 1'b1; end
        PH_ISOLATE:   begin strb.load = 1'b1; strb.lenSel = LEN_STEP_B;   strb.isoOn  = 1'b1; end
        PH_POWER_OFF: begin strb.load = 1'b1; strb.lenSel = LEN_STEP_C;   strb.pwrOff = 1'b1; end
        PH_POWER_ON:  begin strb.load = 1'b1; strb.lenSel = LEN_WAKE_A;   strb.pwrOn  = 1'b1; end
        PH_RELEASE:   begin strb.load = 1'b1; strb.lenSel = LEN_WAKE_B;   strb.isoOff = 1'b1; end
        PH_UNGATE:    begin strb.load = 1'b1; strb.lenSel = LEN_WAKE_C;   strb.clkOn  = 1'b1; end
        default:      strb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_RUN:     begin stateCode = CODE_RUN;      powerCode = LVL_HIGH; end
      PH_IDLE:    begin stateCode = CODE_IDLE;     powerCode = LVL_LOW;  end
      PH_SLEEP:   begin stateCode = CODE_SLEEP;    powerCode = LVL_MIN;  end
      PH_TO_IDLE: begin stateCode = CODE_TO_IDLE;  powerCode = LVL_TRANS; end
      PH_TO_RUN:  begin stateCode = CODE_TO_RUN;   powerCode = LVL_TRANS; end
      PH_GATE, PH_ISOLATE, PH_POWER_OFF:
                  begin stateCode = CODE_TO_SLEEP; powerCode = LVL_TRANS; end
      default:    begin stateCode = CODE_WAKING;   powerCode = LVL_TRANS; end
    endcase
  end

  assign busy = !(phase == PH_RUN || phase == PH_IDLE || phase == PH_SLEEP);

  // R2: a lone light-rest request in run starts idle entry
  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && reqIdle && !reqSleep) |=> phase == PH_TO_IDLE);

  // R3: wake in idle starts the exit
  p_wake_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && wakeEvt) |=> phase == PH_TO_RUN);

  // R5: wake in sleep restores supplies first
  p_wake_sleep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SLEEP && wakeEvt) |=> phase == PH_POWER_ON);

  // R7: deep rest wins in run
  p_sleep_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && reqSleep) |=> phase == PH_GATE);

  // R6: no phase change while the counter is still running
  p_hold_while_counting_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cntZero) |=> phase == $past(phase));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int IDLE_ENTER_CYC  = 10,
  parameter int IDLE_EXIT_CYC   = 10,
  parameter int SLEEP_ENTER_CYC = 90,
  parameter int WAKE_CYC        = 160,
  parameter int NUM_DOMAINS     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqIdle,
  input  logic                   reqSleep,
  input  logic                   wakeEvt,
  output logic                   coreClkEn,
  output logic [NUM_DOMAINS-1:0] isoEn,
  output logic [NUM_DOMAINS-1:0] domPwrEn,
  output logic [2:0]             stateCode,
  output logic [1:0]             powerCode,
  output logic                   busy
);

  strobe_t strb;
  logic    cntZero;

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqIdle   (reqIdle),
    .reqSleep  (reqSleep),
    .wakeEvt   (wakeEvt),
    .cntZero   (cntZero),
    .strb      (strb),
    .stateCode (stateCode),
    .powerCode (powerCode),
    .busy      (busy)
  );

  pwr_mode_dp #(
    .IDLE_ENTER_CYC  (IDLE_ENTER_CYC),
    .IDLE_EXIT_CYC   (IDLE_EXIT_CYC),
    .SLEEP_ENTER_CYC (SLEEP_ENTER_CYC),
    .WAKE_CYC        (WAKE_CYC),
    .NUM_DOMAINS     (NUM_DOMAINS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntZero   (cntZero),
    .coreClkEn (coreClkEn),
    .isoEn     (isoEn),
    .domPwrEn  (domPwrEn)
  );

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int IE = 4, IX = 3, SE = 10, WK = 14, ND = 3;
  localparam logic [ND-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIdle = 1'b0, reqSleep = 1'b0, wakeEvt = 1'b0;
  logic coreClkEn, busy;
  logic [ND-1:0] isoEn, domPwrEn;
  logic [2:0] stateCode;
  logic [1:0] powerCode;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.IDLE_ENTER_CYC(IE), .IDLE_EXIT_CYC(IX), .SLEEP_ENTER_CYC(SE),
                  .WAKE_CYC(WK), .NUM_DOMAINS(ND)) u_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .reqIdle(reqIdle), .reqSleep(reqSleep), .wakeEvt(wakeEvt),
    .coreClkEn(coreClkEn), .isoEn(isoEn), .domPwrEn(domPwrEn),
    .stateCode(stateCode), .powerCode(powerCode), .busy(busy));

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference phases: 0 run,1 to-idle,2 idle,3 to-run,4 stop clk,5 isolate,
  // 6 supply off,7 sleep,8 supply on,9 release,10 clock on
  int ph = 0, el = 1;

  function automatic bit isTrans(int p);
    return !(p == 0 || p == 2 || p == 7);
  endfunction

  function automatic int phLen(int p);
    case (p)
      1: return IE;
      3: return IX;
      4, 5: return SE / 3;
      6: return SE - 2 * (SE / 3);
      8, 9: return WK / 3;
      10: return WK - 2 * (WK / 3);
      default: return 1;
    endcase
  endfunction

  function automatic int succ(int p);
    case (p)
      1: return 2;  3: return 0;  4: return 5;  5: return 6;  6: return 7;
      8: return 9;  9: return 10; default: return 0;
    endcase
  endfunction

  function automatic int expCode(int p);
    case (p)
      0: return 0; 2: return 1; 7: return 2; 1: return 3; 3: return 4;
      4, 5, 6: return 5; default: return 6;
    endcase
  endfunction

  function automatic int expLvl(int p);
    case (p) 0: return 2; 2: return 1; 7: return 0; default: return 3; endcase
  endfunction

  function automatic bit expClk(int p);
    return (p == 0 || p == 3 || p == 10);
  endfunction

  function automatic bit expIso(int p);
    return (p == 5 || p == 6 || p == 7 || p == 8);
  endfunction

  function automatic bit expPwr(int p);
    return !(p == 6 || p == 7);
  endfunction

  function automatic string tagOf(int p);
    case (p)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      4, 5, 6, 7: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph <= 0; el <= 1;
    end else if (isTrans(ph)) begin
      if (el >= phLen(ph)) begin ph <= succ(ph); el <= 1; end
      else el <= el + 1;
    end else begin
      el <= 1;
      case (ph)
        0: if (reqSleep) ph <= 4; else if (reqIdle) ph <= 1;
        2: if (wakeEvt) ph <= 3; else if (reqSleep) ph <= 4;
        7: if (wakeEvt) ph <= 8;
        default: ;
      endcase
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(tagOf(ph), "stateCode", int'(stateCode), expCode(ph));
    check(tagOf(ph), "coreClkEn", int'(coreClkEn), int'(expClk(ph)));
    check(tagOf(ph), "isoEn", int'(isoEn), expIso(ph) ? int'(ALL1) : 0);
    check(tagOf(ph), "domPwrEn", int'(domPwrEn), expPwr(ph) ? int'(ALL1) : 0);
    check("R6", "busy", int'(busy), int'(isTrans(ph)));
    check("R8", "powerCode", int'(powerCode), expLvl(ph));
    check("R9", "isolation covers unsupplied", int'((isoEn | domPwrEn) == ALL1), 1);
  endtask

  task automatic tick(bit i, bit s, bit w);
    reqIdle = i; reqSleep = s; wakeEvt = w;
    @(negedge clk);
    compareAll();
  endtask

  task automatic waitFor(int p);
    for (int k = 0; k < 500 && ph != p; k++) tick(0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset stateCode", int'(stateCode), 0);
    check("R1", "reset coreClkEn", int'(coreClkEn), 1);
    check("R1", "reset isoEn", int'(isoEn), 0);
    check("R1", "reset domPwrEn", int'(domPwrEn), int'(ALL1));
    check("R1", "reset busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R7: both requests in run -> deep rest
    tick(1, 1, 0);
    check("R7", "sleep beats idle in run", int'(stateCode), 5);
    waitFor(7);
    tick(0, 1, 0);
    check("R7", "deep request ignored in sleep", int'(stateCode), 2);
    tick(1, 0, 0);
    check("R7", "light request ignored in sleep", int'(stateCode), 2);
    tick(0, 0, 1);
    check("R5", "wake from sleep starts", int'(stateCode), 6);
    waitFor(0);
    tick(0, 0, 1);
    check("R7", "wake ignored in run", int'(stateCode), 0);
    tick(1, 0, 0);
    check("R2", "idle entry starts", int'(stateCode), 3);
    tick(0, 1, 1);
    check("R6", "inputs ignored while busy", int'(stateCode), 3);
    waitFor(2);
    tick(1, 0, 0);
    check("R7", "light request ignored in idle", int'(stateCode), 1);
    tick(0, 1, 1);
    check("R7", "wake beats sleep in idle", int'(stateCode), 4);
    waitFor(0);
    tick(1, 0, 0);
    waitFor(2);
    tick(0, 1, 0);
    check("R4", "sleep entry from idle", int'(stateCode), 5);
    waitFor(7);
    tick(0, 0, 1);
    waitFor(0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      r = $urandom_range(0, 99);
      tick(r < 10, (r >= 10 && r < 15) || r == 99, (r >= 40 && r < 48) || r == 99);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule